// File: doc/BRIEF.md
# SPI Lane FIFO with Watermark Flags

This block buffers the data of one SPI direction between a register or DMA port on one side and the serial shift engine on the other. It holds 256 bytes of storage. That storage is shared by entries of 8, 16 or 32 bits, so it holds 256, 128 or 64 entries. Its fill level is reported in entries, in a status word that also carries full and empty flags.

Software controls the FIFO through an operation write. One bit empties the storage and the other sets whether the FIFO runs. An 8-bit threshold in the control word drives a threshold-reached output. Three 6-bit watermark marks, named stop, low and high, are compared on every cycle against the level counted in 32-bit units. These comparisons drive the outputs that a DMA pacer or an interrupt unit would watch.

A push into a full FIFO and a pop from an empty one do not corrupt the contents. Each of them sets a sticky error flag instead.

Top module: `spi_lane_fifo`

## Requirements
- R1: After reset the FIFO is stopped and empty. The status word reads 0x200, and the overflow and underflow flags are clear.
- R2: An operation write with bit 0 set empties the FIFO and clears the overflow and underflow flags. Bit 1 of the same write sets the running state, so a write of zero stops the FIFO without emptying it. A push or pop in the same cycle as an operation write is ignored.
- R3: While the FIFO is stopped, pushes and pops change neither the contents nor the flags, and the status word remains readable.
- R4: Control bits 1:0 select the entry width: 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. The capacity is 256, 128 or 64 entries. The popped word carries the entry in its low bits with the upper bits zero.
- R5: Entries are popped in the order they were pushed, with their data unchanged.
- R6: The status word carries the entry level modulo 256 in bits 7:0, full in bit 8 and empty in bit 9. Full and empty are never set together.
- R7: A push while full is dropped and sets the sticky overflow flag.
- R8: While the FIFO is empty the pop data reads zero. A pop while empty sets the sticky underflow flag.
- R9: The threshold is control bits 9:2. The threshold output is high while the entry level is greater than or equal to it.
- R10: The mark word holds stop in bits 5:0, low in bits 15:10 and high in bits 25:20. Let W be the stored bytes divided by 4, rounded down. low_hit is W ≤ low, high_hit is W ≥ high, and stop_hit is W ≥ stop.
- R11: A push and a pop in the same cycle, on a FIFO that is neither empty nor full, both take effect and leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_wr | input | 1 | Operation write strobe |
| op_val | input | 2 | Operation value: bit 0 empties the FIFO, bit 1 runs it |
| cfg_ctrl | input | 10 | Width in bits 1:0, threshold in bits 9:2 |
| cfg_marks | input | 26 | Stop, low and high watermark marks |
| push | input | 1 | Push one entry |
| push_data | input | 32 | Entry to push, in the low bits |
| pop | input | 1 | Pop the head entry |
| pop_data | output | 32 | Head entry, zero-extended; zero when the FIFO is empty |
| status | output | 10 | Level in bits 7:0, full in bit 8, empty in bit 9 |
| running | output | 1 | FIFO is started |
| ovf | output | 1 | Sticky overflow flag |
| udf | output | 1 | Sticky underflow flag |
| thresh_hit | output | 1 | Level has reached the threshold |
| stop_hit | output | 1 | Stop watermark reached |
| low_hit | output | 1 | Level at or below the low watermark |
| high_hit | output | 1 | Level at or above the high watermark |

## Verification
The assertions cover the rules that hold on every cycle:
- full and empty are never set together;
- a clearing operation leaves the FIFO empty with both error flags clear;
- the status holds still while the FIFO is stopped;
- overflow rises only after a push into a full FIFO;
- an empty FIFO presents zero data and keeps a nonzero threshold unreached.

Only the directed scenarios can show data ordering, the masking of entries per width, the capacity in each width with its 256-entry wrap of the level field, and the exact crossing points of the threshold and watermark outputs.

// File: rtl/lane_fifo_pkg.sv
package lane_fifo_pkg;

    typedef enum logic [1:0] {
        EW_8   = 2'd0,
        EW_16  = 2'd1,
        EW_32  = 2'd2,
        EW_32X = 2'd3
    } ent_width_e;

    typedef struct packed {
        logic       empty;
        logic       full;
        logic [7:0] level;
    } fifo_stat_t;

    typedef struct packed {
        logic [5:0] high;
        logic [3:0] gap1;
        logic [5:0] low;
        logic [3:0] gap0;
        logic [5:0] stop;
    } marks_t;

    typedef struct packed {
        logic [7:0] thresh;
        ent_width_e width;
    } ctrl_t;

    function automatic logic [2:0] entry_bytes(ent_width_e w);
        case (w)
            EW_8:    return 3'd1;
            EW_16:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] entry_shift(ent_width_e w);
        case (w)
            EW_8:    return 2'd0;
            EW_16:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [31:0] entry_mask(ent_width_e w);
        case (w)
            EW_8:    return 32'h0000_00FF;
            EW_16:   return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/lane_fifo_store.sv
module lane_fifo_store #(
    parameter int CAP_BYTES = 256,
    parameter int LANES     = 4,
    localparam int PTR_W    = $clog2(CAP_BYTES)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [2:0]         wr_bytes,
    input  logic [PTR_W-1:0]   wr_ptr,
    input  logic [8*LANES-1:0] wr_data,
    input  logic [PTR_W-1:0]   rd_ptr,
    output logic [8*LANES-1:0] rd_data
);
    logic [7:0] mem [CAP_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (l < int'(wr_bytes))
                    mem[wr_ptr + PTR_W'(l)] <= wr_data[8*l +: 8];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign rd_data[8*g +: 8] = mem[rd_ptr + PTR_W'(g)];
    end
endmodule

// File: rtl/lane_fifo_ctrl.sv
module lane_fifo_ctrl #(
    parameter int CAP_BYTES = 256,
    localparam int PTR_W    = $clog2(CAP_BYTES),
    localparam int CNT_W    = $clog2(CAP_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_wr,
    input  logic [1:0]       op_val,
    input  logic             push,
    input  logic             pop,
    input  logic [2:0]       nbytes,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] used,
    output logic             running,
    output logic             ovf,
    output logic             udf,
    output logic             push_ok
);
    logic             active;
    logic             pop_ok;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] room;

    assign step    = CNT_W'(nbytes);
    assign room    = CNT_W'(CAP_BYTES) - used;
    assign active  = running && !op_wr;
    assign push_ok = active && push && (room >= step);
    assign pop_ok  = active && pop && (used >= step);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            used    <= '0;
            running <= 1'b0;
            ovf     <= 1'b0;
            udf     <= 1'b0;
        end else if (op_wr) begin
            running <= op_val[1];
            if (op_val[0]) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                used   <= '0;
                ovf    <= 1'b0;
                udf    <= 1'b0;
            end
        end else if (running) begin
            if (push_ok) wr_ptr <= wr_ptr + PTR_W'(nbytes);
            if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(nbytes);
            case ({push_ok, pop_ok})
                2'b10:   used <= used + step;
                2'b01:   used <= used - step;
                default: used <= used;
            endcase
            if (push && !push_ok) ovf <= 1'b1;
            if (pop && !pop_ok)   udf <= 1'b1;
        end
    end
endmodule

// File: rtl/lane_fifo_marks.sv
module lane_fifo_marks
    import lane_fifo_pkg::*;
#(
    parameter int CAP_BYTES = 256,
    localparam int CNT_W    = $clog2(CAP_BYTES + 1)
) (
    input  logic [CNT_W-1:0] used,
    input  ctrl_t            ctrl,
    input  marks_t           marks,
    output fifo_stat_t       stat,
    output logic             thresh_hit,
    output logic             stop_hit,
    output logic             low_hit,
    output logic             high_hit
);
    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] level_w;

    assign level   = used >> entry_shift(ctrl.width);
    assign level_w = used >> 2;

    always_comb begin
        stat.level = level[7:0];
        stat.full  = (used == CNT_W'(CAP_BYTES));
        stat.empty = (used == '0);
    end

    assign thresh_hit = level   >= CNT_W'(ctrl.thresh);
    assign stop_hit   = level_w >= CNT_W'(marks.stop);
    assign low_hit    = level_w <= CNT_W'(marks.low);
    assign high_hit   = level_w >= CNT_W'(marks.high);
endmodule

// File: rtl/spi_lane_fifo.sv
module spi_lane_fifo
    import lane_fifo_pkg::*;
#(
    parameter int CAP_BYTES = 256,
    localparam int PTR_W    = $clog2(CAP_BYTES),
    localparam int CNT_W    = $clog2(CAP_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_wr,
    input  logic [1:0]  op_val,
    input  logic [9:0]  cfg_ctrl,
    input  logic [25:0] cfg_marks,
    input  logic        push,
    input  logic [31:0] push_data,
    input  logic        pop,
    output logic [31:0] pop_data,
    output logic [9:0]  status,
    output logic        running,
    output logic        ovf,
    output logic        udf,
    output logic        thresh_hit,
    output logic        stop_hit,
    output logic        low_hit,
    output logic        high_hit
);
    ctrl_t            ctrl;
    fifo_stat_t       stat;
    logic [2:0]       nbytes;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] used;
    logic             push_ok;
    logic [31:0]      head;

    assign ctrl   = ctrl_t'(cfg_ctrl);
    assign nbytes = entry_bytes(ctrl.width);

    lane_fifo_ctrl #(.CAP_BYTES(CAP_BYTES)) u_ctrl (
        .clk(clk), .rst(rst), .op_wr(op_wr), .op_val(op_val),
        .push(push), .pop(pop), .nbytes(nbytes),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .used(used),
        .running(running), .ovf(ovf), .udf(udf), .push_ok(push_ok)
    );

    lane_fifo_store #(.CAP_BYTES(CAP_BYTES), .LANES(4)) u_store (
        .clk(clk), .we(push_ok), .wr_bytes(nbytes), .wr_ptr(wr_ptr),
        .wr_data(push_data), .rd_ptr(rd_ptr), .rd_data(head)
    );

    lane_fifo_marks #(.CAP_BYTES(CAP_BYTES)) u_marks (
        .used(used), .ctrl(ctrl), .marks(marks_t'(cfg_marks)),
        .stat(stat), .thresh_hit(thresh_hit), .stop_hit(stop_hit),
        .low_hit(low_hit), .high_hit(high_hit)
    );

    assign status   = stat;
    assign pop_data = stat.empty ? 32'h0 : (head & entry_mask(ctrl.width));
endmodule

// File: rtl/lane_fifo_chk.sv
module lane_fifo_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_wr,
    input logic [1:0]  op_val,
    input logic [9:0]  cfg_ctrl,
    input logic        push,
    input logic [31:0] pop_data,
    input logic [9:0]  status,
    input logic        running,
    input logic        ovf,
    input logic        udf,
    input logic        thresh_hit
);
    p_flag_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(status[8] && status[9]));

    p_clear_empties_r2: assert property (@(posedge clk) disable iff (rst)
        (op_wr && op_val[0]) |=> (status[9] && !ovf && !udf));

    p_run_follows_r2: assert property (@(posedge clk) disable iff (rst)
        op_wr |=> (running == $past(op_val[1])));

    p_stopped_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!running && !op_wr) |=> $stable(status));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> ($past(push) && $past(status[8])));

    p_empty_zero_r8: assert property (@(posedge clk) disable iff (rst)
        status[9] |-> (pop_data == 32'h0));

    p_thresh_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (status[9] && cfg_ctrl[9:2] != 8'h0) |-> !thresh_hit);
endmodule

bind spi_lane_fifo lane_fifo_chk u_lane_fifo_chk (
    .clk(clk), .rst(rst), .op_wr(op_wr), .op_val(op_val),
    .cfg_ctrl(cfg_ctrl), .push(push), .pop_data(pop_data),
    .status(status), .running(running), .ovf(ovf), .udf(udf),
    .thresh_hit(thresh_hit)
);

// File: tb/test_spi_lane_fifo.sv
module test_spi_lane_fifo;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_wr = 1'b0;
    logic [1:0]  op_val = 2'b00;
    logic [9:0]  cfg_ctrl = '0;
    logic [25:0] cfg_marks = '0;
    logic        push = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop = 1'b0;
    logic [31:0] pop_data;
    logic [9:0]  status;
    logic        running, ovf, udf, thresh_hit, stop_hit, low_hit, high_hit;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_lane_fifo i_spi_lane_fifo (
        .clk(clk), .rst(rst), .op_wr(op_wr), .op_val(op_val),
        .cfg_ctrl(cfg_ctrl), .cfg_marks(cfg_marks), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .status(status), .running(running), .ovf(ovf), .udf(udf),
        .thresh_hit(thresh_hit), .stop_hit(stop_hit), .low_hit(low_hit),
        .high_hit(high_hit)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_op(logic [1:0] v);
        op_wr = 1'b1; op_val = v;
        cyc();
        op_wr = 1'b0; op_val = 2'b00;
    endtask

    task automatic do_push(logic [31:0] d);
        push = 1'b1; push_data = d;
        cyc();
        push = 1'b0;
    endtask

    task automatic do_pop(string tag, logic [31:0] exp);
        chk(tag, pop_data, exp);
        pop = 1'b1;
        cyc();
        pop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", 32'(status), 32'h200);
        chk("R1 running", 32'(running), 0);
        chk("R1 ovf/udf", {30'd0, ovf, udf}, 0);
    endtask

    task automatic t_stopped();
        cfg_ctrl = 10'd0;
        do_push(32'h11);
        chk("R3 push while stopped", 32'(status), 32'h200);
        do_op(2'b10);
        do_push(32'h21);
        do_push(32'h22);
        do_op(2'b00);
        do_push(32'h23);
        do_pop("R3 head while stopped", 32'h21);
        chk("R3 level held", 32'(status), 32'h002);
        chk("R3 no flags", {30'd0, ovf, udf}, 0);
        do_op(2'b10);
        do_pop("R3 resumed head", 32'h21);
        do_pop("R3 resumed next", 32'h22);
        chk("R3 emptied", 32'(status), 32'h200);
    endtask

    task automatic t_op_cycle();
        do_op(2'b11);
        push = 1'b1; push_data = 32'h5A;
        op_wr = 1'b1; op_val = 2'b10;
        cyc();
        push = 1'b0; op_wr = 1'b0;
        chk("R2 push in op cycle ignored", 32'(status), 32'h200);
        do_op(2'b00);
        chk("R2 zero write stops", 32'(running), 0);
    endtask

    task automatic t_byte_order();
        cfg_ctrl = 10'd0;
        do_op(2'b11);
        do_push(32'h1234_56A1);
        do_push(32'hFFFF_FFA2);
        do_push(32'h0000_00A3);
        chk("R6 level 3", 32'(status), 32'h003);
        do_pop("R4 byte mask/R5 order 1", 32'hA1);
        do_pop("R5 order 2", 32'hA2);
        do_pop("R5 order 3", 32'hA3);
    endtask

    task automatic t_full_byte();
        int bad = 0;
        cfg_ctrl = 10'd0;
        do_op(2'b11);
        for (int i = 0; i < 256; i++) do_push(32'(i + 1));
        chk("R4/R6 byte full", 32'(status), 32'h100);
        chk("R7 no ovf yet", 32'(ovf), 0);
        do_push(32'hEE);
        chk("R7 ovf set", 32'(ovf), 1);
        chk("R7 still full", 32'(status), 32'h100);
        for (int i = 0; i < 256; i++) begin
            if (pop_data !== 32'((i + 1) & 8'hFF)) bad++;
            pop = 1'b1; cyc(); pop = 1'b0;
        end
        chk("R5 byte drain order", 32'(bad), 0);
        chk("R6 drained empty", 32'(status), 32'h200);
        chk("R7 ovf sticky", 32'(ovf), 1);
    endtask

    task automatic t_half();
        cfg_ctrl = 10'd1;
        do_op(2'b11);
        chk("R2 clear drops ovf", 32'(ovf), 0);
        for (int i = 0; i < 128; i++) do_push(32'hABC0_0000 | 32'(i));
        chk("R4 half full 128", 32'(status), 32'h180);
        do_push(32'h1);
        chk("R7 half ovf", 32'(ovf), 1);
        do_pop("R4 half mask", 32'h0000_0000);
        do_pop("R4 half next", 32'h0000_0001);
        chk("R6 half level 126", 32'(status), 32'h07E);
    endtask

    task automatic t_word();
        cfg_ctrl = 10'd2;
        do_op(2'b11);
        for (int i = 0; i < 64; i++) do_push(32'hC0DE_0000 + 32'(i));
        chk("R4 word full 64", 32'(status), 32'h140);
        do_pop("R4 word data", 32'hC0DE_0000);
        cfg_ctrl = 10'd3;
        do_pop("R4 code 3 is 32-bit", 32'hC0DE_0001);
    endtask

    task automatic t_underflow();
        cfg_ctrl = 10'd0;
        do_op(2'b11);
        do_pop("R8 empty data zero", 32'h0);
        chk("R8 udf set", 32'(udf), 1);
        chk("R8 still empty", 32'(status), 32'h200);
        do_op(2'b11);
        chk("R2 clear drops udf", 32'(udf), 0);
    endtask

    task automatic t_thresh();
        cfg_ctrl = {8'd5, 2'd1};
        do_op(2'b11);
        for (int i = 0; i < 4; i++) do_push(32'(i));
        chk("R9 below threshold", 32'(thresh_hit), 0);
        do_push(32'h9);
        chk("R9 at threshold", 32'(thresh_hit), 1);
    endtask

    task automatic t_marks();
        cfg_ctrl = 10'd0;
        cfg_marks = {6'd3, 4'd0, 6'd2, 4'd0, 6'd2};
        do_op(2'b11);
        for (int i = 0; i < 9; i++) do_push(32'(i));
        chk("R10 low at W=2", 32'(low_hit), 1);
        chk("R10 high at W=2", 32'(high_hit), 0);
        chk("R10 stop at W=2", 32'(stop_hit), 1);
        for (int i = 0; i < 4; i++) do_push(32'(i));
        chk("R10 low at W=3", 32'(low_hit), 0);
        chk("R10 high at W=3", 32'(high_hit), 1);
    endtask

    task automatic t_simul();
        cfg_ctrl = 10'd0;
        do_op(2'b11);
        do_push(32'h31); do_push(32'h32); do_push(32'h33);
        chk("R11 simultaneous head", pop_data, 32'h31);
        push = 1'b1; push_data = 32'h34; pop = 1'b1;
        cyc();
        push = 1'b0; pop = 1'b0;
        chk("R11 level unchanged", 32'(status), 32'h003);
        do_pop("R11 next 32", 32'h32);
        do_pop("R11 next 33", 32'h33);
        do_pop("R11 pushed 34", 32'h34);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_stopped();
        t_op_cycle();
        t_byte_order();
        t_full_byte();
        t_half();
        t_word();
        t_underflow();
        t_thresh();
        t_marks();
        t_simul();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule